// File: doc/BRIEF.md
# Storage key reference/change updater

This block holds one small key per page of absolute storage and keeps two tracking bits in each key up to date. One bit records that the page was referenced and one records that it was changed. After the address translator has produced an absolute address, it hands that address to the block together with the access type and the permission flags of the translation. The block reads the key for that page, merges in the tracking bits, writes the key back, and returns the permission flags, possibly narrowed.

A read or instruction fetch on a page whose change bit is still clear removes the write permission from the returned flags. The cached translation then stays write-protected until a store actually happens, so the first real store always faults back through this block and gets its change bit recorded. Addresses at or above the configured memory size bypass the key array entirely.

A separate host port reads any key combinationally and writes any key in one cycle. A host write always wins over an update in flight, and that update is re-run against the new key value. The caller issues one request at a time and waits for the done strobe before issuing the next one. Requests issued while an update is in flight are dropped.

Top module: `skey_updater`

## Requirements
- R1: After reset every key reads as zero on the host port, and done_o and flags_o are low.
- R2: The key index is the absolute address shifted right by PAGE_BITS, taken modulo NUM_PAGES. A host write with host_we_i high stores host_wkey_i at host_idx_i, and host_rkey_o always shows the key at host_idx_i.
- R3: Every in-range access of any type leaves key bit 2 (reference) set. All other key bits keep their value, apart from bit 1 as given in R4.
- R4: An in-range access of type 1 (store) leaves key bit 1 (change) set.
- R5: Access types 0 (load), 2 (fetch) and 3 (treated as load) clear flag bit 1 (write) in flags_o when the key's change bit was clear before the update. When it was set, the flags are returned unchanged. Flag bit 0 (read) and bit 2 (execute) always pass through.
- R6: For a store, flags_o equals the incoming flags.
- R7: A request with req_addr_i >= MEM_BYTES modifies no key. It returns its flags unchanged, and done_o is high in the cycle after the capturing edge.
- R8: For an in-range request captured at edge E0, the key is written back at edge E2. done_o is high for exactly the one cycle after E2, and flags_o holds the result from then on.
- R9: A host write while an update is in its read phase or write-back phase takes priority. The update is retried from a fresh read of the key, so the final key is the host value plus the update bits. A collision in the read phase delays done_o by one cycle, and a collision in the write-back phase delays it by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, sampled when idle |
| req_addr_i | input | ADDR_W | Absolute byte address |
| req_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| req_flags_i | input | 3 | Incoming flags: bit 0 read, bit 1 write, bit 2 execute |
| flags_o | output | 3 | Adjusted flags of the last completed request |
| done_o | output | 1 | One-cycle completion strobe |
| host_we_i | input | 1 | Host key write enable |
| host_idx_i | input | IDX_W | Host key index |
| host_wkey_i | input | KEY_W | Host write data |
| host_rkey_o | output | KEY_W | Key at host_idx_i |

## Verification
The bench uses the default configuration. Pages are 256 bytes, there are 64 keys of 7 bits, and the memory size is 48 pages, so indices 48 to 63 can only be reached through the host port and through out-of-range addresses that alias onto them. With this size, every in-range page can be swept under all four access codes and all eight flag patterns, each with a preloaded key whose change bit varies. The first and last out-of-range addresses and the last in-range byte can be hit directly. Host collisions are forced in both the read phase and the write-back phase.

// File: rtl/skey_pkg.sv
package skey_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } upd_state_e;

  localparam int FLG_W       = 3;
  localparam int FLG_RD      = 0;
  localparam int FLG_WR      = 1;
  localparam int FLG_EX      = 2;
  localparam int KEY_REF_BIT = 2;
  localparam int KEY_CHG_BIT = 1;
endpackage

// File: rtl/skey_array.sv
module skey_array #(
  parameter int NUM_PAGES = 64,
  parameter int KEY_W     = 7,
  localparam int IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic [KEY_W-1:0] host_wkey_i,
  input  logic             upd_we_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [KEY_W-1:0] upd_key_i,
  input  logic [IDX_W-1:0] rd_idx_a_i,
  output logic [KEY_W-1:0] rd_key_a_o,
  output logic [KEY_W-1:0] rd_key_b_o
);
  import skey_pkg::*;

  logic [KEY_W-1:0] key_q [NUM_PAGES];
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [KEY_W-1:0] wr_key;

  // host port wins the single write port
  always_comb begin
    wr_en  = host_we_i | upd_we_i;
    wr_idx = host_we_i ? host_idx_i  : upd_idx_i;
    wr_key = host_we_i ? host_wkey_i : upd_key_i;
  end

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 key_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))       key_q[g] <= wr_key;
    end
  end

  assign rd_key_a_o = key_q[rd_idx_a_i];
  assign rd_key_b_o = key_q[host_idx_i];

  AST_HOST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |-> !upd_we_i); // R9
  AST_UPD_HAS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_we_i |-> upd_key_i[KEY_REF_BIT]); // R3
endmodule

// File: rtl/skey_calc.sv
module skey_calc #(
  parameter int KEY_W = 7
) (
  input  logic [KEY_W-1:0]           old_key_i,
  input  logic [1:0]                 acc_i,
  input  logic [skey_pkg::FLG_W-1:0] flags_i,
  output logic [KEY_W-1:0]           new_key_o,
  output logic [skey_pkg::FLG_W-1:0] flags_o
);
  import skey_pkg::*;

  logic is_store;

  always_comb begin
    is_store  = (acc_i == ACC_STORE);
    new_key_o = old_key_i;
    new_key_o[KEY_REF_BIT] = 1'b1;
    if (is_store) new_key_o[KEY_CHG_BIT] = 1'b1;
    flags_o = flags_i;
    // keep the entry write-protected until a store has marked the page
    if (!is_store && !old_key_i[KEY_CHG_BIT]) flags_o[FLG_WR] = 1'b0;
  end
endmodule

// File: rtl/skey_seq.sv
module skey_seq #(
  parameter int KEY_W = 7,
  parameter int IDX_W = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic                       req_in_range_i,
  input  logic [IDX_W-1:0]           req_idx_i,
  input  logic [1:0]                 req_acc_i,
  input  logic [skey_pkg::FLG_W-1:0] req_flags_i,
  input  logic                       host_we_i,
  input  logic [KEY_W-1:0]           calc_key_i,
  input  logic [skey_pkg::FLG_W-1:0] calc_flags_i,
  output logic [IDX_W-1:0]           cur_idx_o,
  output logic [1:0]                 cur_acc_o,
  output logic [skey_pkg::FLG_W-1:0] cur_flags_o,
  output logic                       upd_we_o,
  output logic [KEY_W-1:0]           upd_key_o,
  output logic                       done_o,
  output logic [skey_pkg::FLG_W-1:0] flags_o
);
  import skey_pkg::*;

  upd_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [1:0]         acc_q;
  logic [FLG_W-1:0]   flin_q;
  logic [KEY_W-1:0]   key_q;
  logic [FLG_W-1:0]   flout_q;
  logic [FLG_W-1:0]   flags_q;
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      acc_q   <= '0;
      flin_q  <= '0;
      key_q   <= '0;
      flout_q <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          idx_q  <= req_idx_i;
          acc_q  <= req_acc_i;
          flin_q <= req_flags_i;
          if (req_in_range_i) begin
            state_q <= ST_RD;
          end else begin
            done_q  <= 1'b1;
            flags_q <= req_flags_i;
          end
        end
        ST_RD: if (!host_we_i) begin
          key_q   <= calc_key_i;
          flout_q <= calc_flags_i;
          state_q <= ST_WR;
        end
        ST_WR: if (host_we_i) begin
          state_q <= ST_RD;
        end else begin
          done_q  <= 1'b1;
          flags_q <= flout_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign upd_we_o    = (state_q == ST_WR) && !host_we_i;
  assign upd_key_o   = key_q;
  assign cur_idx_o   = idx_q;
  assign cur_acc_o   = acc_q;
  assign cur_flags_o = flin_q;
  assign done_o      = done_q;
  assign flags_o     = flags_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_STORE_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_we_o && acc_q == ACC_STORE) |-> upd_key_o[KEY_CHG_BIT]); // R4
  AST_FLAGS_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((flags_q & ~flin_q) == '0)); // R5
  AST_STORE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && acc_q == ACC_STORE) |-> (flags_q == flin_q)); // R6
endmodule

// File: rtl/skey_updater.sv
module skey_updater #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 8,
  parameter int NUM_PAGES = 64,
  parameter int KEY_W     = 7,
  parameter int MEM_BYTES = 12288,
  localparam int IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_acc_i,
  input  logic [2:0]        req_flags_i,
  output logic [2:0]        flags_o,
  output logic              done_o,
  input  logic              host_we_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic [KEY_W-1:0]  host_wkey_i,
  output logic [KEY_W-1:0]  host_rkey_o
);
  import skey_pkg::*;

  localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W+1)'(MEM_BYTES);

  logic             req_in_range;
  logic [IDX_W-1:0] req_idx;
  logic [IDX_W-1:0] cur_idx;
  logic [1:0]       cur_acc;
  logic [FLG_W-1:0] cur_flags;
  logic [KEY_W-1:0] old_key;
  logic [KEY_W-1:0] calc_key;
  logic [FLG_W-1:0] calc_flags;
  logic             upd_we;
  logic [KEY_W-1:0] upd_key;

  assign req_in_range = ({1'b0, req_addr_i} < MEM_LIM);
  assign req_idx      = req_addr_i[PAGE_BITS +: IDX_W];

  skey_seq #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .req_valid_i,
    .req_in_range_i (req_in_range),
    .req_idx_i      (req_idx),
    .req_acc_i, .req_flags_i, .host_we_i,
    .calc_key_i     (calc_key),
    .calc_flags_i   (calc_flags),
    .cur_idx_o      (cur_idx),
    .cur_acc_o      (cur_acc),
    .cur_flags_o    (cur_flags),
    .upd_we_o       (upd_we),
    .upd_key_o      (upd_key),
    .done_o, .flags_o
  );

  skey_calc #(.KEY_W(KEY_W)) u_calc (
    .old_key_i (old_key),
    .acc_i     (cur_acc),
    .flags_i   (cur_flags),
    .new_key_o (calc_key),
    .flags_o   (calc_flags)
  );

  skey_array #(.NUM_PAGES(NUM_PAGES), .KEY_W(KEY_W)) u_array (
    .clk_i, .rst_ni, .host_we_i, .host_idx_i, .host_wkey_i,
    .upd_we_i   (upd_we),
    .upd_idx_i  (cur_idx),
    .upd_key_i  (upd_key),
    .rd_idx_a_i (cur_idx),
    .rd_key_a_o (old_key),
    .rd_key_b_o (host_rkey_o)
  );

  AST_OOR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_in_range && u_seq.state_q == ST_IDLE) |=> done_o); // R7
endmodule

// File: tb/tb_skey_updater.sv
module tb_skey_updater;
  localparam int CLK_P = 10;
  localparam int ADDR_W = 16, PAGE_BITS = 8, NUM_PAGES = 64, KEY_W = 7, MEM_BYTES = 12288;
  localparam int IDX_W = 6;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_acc = '0;
  logic [2:0] req_flags = '0;
  logic [2:0] flags_o;
  logic done_o;
  logic host_we = 0;
  logic [IDX_W-1:0] host_idx = '0;
  logic [KEY_W-1:0] host_wkey = '0, host_rkey;

  int checks = 0, errors = 0;
  logic [KEY_W-1:0] model [NUM_PAGES];

  always #(CLK_P/2) clk = ~clk;

  skey_updater #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES),
                 .KEY_W(KEY_W), .MEM_BYTES(MEM_BYTES)) dut (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_acc_i(req_acc), .req_flags_i(req_flags), .flags_o, .done_o,
    .host_we_i(host_we), .host_idx_i(host_idx), .host_wkey_i(host_wkey),
    .host_rkey_o(host_rkey));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input int idx, input int key);
    @(negedge clk);
    host_we = 1; host_idx = IDX_W'(idx); host_wkey = KEY_W'(key);
    @(negedge clk);
    host_we = 0;
    model[idx] = KEY_W'(key);
  endtask

  task automatic read_key(input int idx, output int key);
    host_idx = IDX_W'(idx);
    #1;
    key = int'(host_rkey);
  endtask

  // hd: 0 none, 1 host write in read phase, 2 in write-back phase (same page)
  task automatic do_req(input int addr, input int acc, input int fl,
                        input int hd, input int hkey, output int lat);
    int n;
    @(negedge clk);
    req_valid = 1; req_addr = ADDR_W'(addr); req_acc = 2'(acc); req_flags = 3'(fl);
    host_idx = IDX_W'((addr >> PAGE_BITS) % NUM_PAGES);
    host_wkey = KEY_W'(hkey);
    lat = -1;
    for (n = 1; n <= 20 && lat < 0; n++) begin
      @(negedge clk);
      req_valid = 0;
      host_we = (hd != 0 && n == hd);
      if (done_o) lat = n;
    end
    host_we = 0;
    if (lat < 0) chk("R8 done timeout", 0, 1);
  endtask

  initial begin
    int k, lat, idx, old, expf, expk;
    for (int i = 0; i < NUM_PAGES; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done_o", int'(done_o), 0);
    chk("R1 flags_o", int'(flags_o), 0);
    for (int i = 0; i < NUM_PAGES; i++) begin
      read_key(i, k); chk("R1 key zero", k, 0);
    end
    rst_ni = 1;
    // R2 host write/read sweep
    for (int i = 0; i < NUM_PAGES; i++) host_write(i, (i * 37 + 5) & 8'h7f);
    for (int i = 0; i < NUM_PAGES; i++) begin
      read_key(i, k); chk("R2 host readback", k, int'(model[i]));
    end
    // R3 R4 R5 R6 R8: in-range sweep
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < MEM_BYTES / 256; p++)
        for (int f = 0; f < 8; f++) begin
          host_write(p, (p * 13 + f * 5 + a * 3) & 8'h7f);
          old = int'(model[p]);
          do_req(p * 256 + ((p * 7 + f) & 8'hff), a, f, 0, 0, lat);
          expf = (a == 1 || (old & 2) != 0) ? f : (f & 5);
          expk = old | 4 | ((a == 1) ? 2 : 0);
          model[p] = KEY_W'(expk);
          chk((a == 1) ? "R6 store flags" : "R5 load/fetch flags", int'(flags_o), expf);
          read_key(p, k);
          chk((a == 1) ? "R4 store key" : "R3 ref key", k, expk);
          chk("R8 latency", lat, 3);
          @(negedge clk);
          chk("R8 done one cycle", int'(done_o), 0);
        end
    // R7 out of range, boundary
    host_write(48, 8'h11);
    do_req(MEM_BYTES, 1, 3, 0, 0, lat);
    chk("R7 oor flags", int'(flags_o), 3);
    chk("R7 oor latency", lat, 1);
    read_key(48, k); chk("R7 oor key 48", k, 8'h11);
    host_write(63, 8'h20);
    do_req(16'hffff, 0, 7, 0, 0, lat);
    chk("R7 oor flags top", int'(flags_o), 7);
    read_key(63, k); chk("R7 oor key 63", k, 8'h20);
    host_write(47, 0);
    do_req(MEM_BYTES - 1, 1, 7, 0, 0, lat);
    read_key(47, k); chk("R7 last in-range key", k, 6);
    chk("R7 last in-range latency", lat, 3);
    // R9 host collisions
    host_write(5, 0);
    do_req(5 * 256 + 3, 1, 7, 2, 8'h41, lat);
    read_key(5, k); chk("R9 wr-phase key", k, 8'h47);
    chk("R9 wr-phase latency", lat, 5);
    chk("R9 wr-phase flags", int'(flags_o), 7);
    host_write(6, 0);
    do_req(6 * 256, 0, 7, 1, 8'h02, lat);
    read_key(6, k); chk("R9 rd-phase key", k, 8'h06);
    chk("R9 rd-phase latency", lat, 4);
    chk("R9 rd-phase flags", int'(flags_o), 7);
    host_write(7, 8'h02);
    do_req(7 * 256, 2, 7, 2, 8'h00, lat);
    read_key(7, k); chk("R9 fetch retry key", k, 8'h04);
    chk("R9 fetch retry flags", int'(flags_o), 5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule